// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block answers the processor's interrupt-acknowledge pulses by placing the right bytes on the data bus. It sits between a priority resolver, which supplies the winning level and says whether any request is pending, and the processor's acknowledge strobe. The first acknowledge pulse of a sequence latches the level and the mode. The block then strobes the resolver so that it marks the level in service and drops its request.

Two response formats are supported. In call mode the processor pulses acknowledge three times and receives a call opcode, then the low byte of the service address, then the high byte. The low byte places the level at a spacing of 4 or 8 bytes above a programmed base. In type-number mode the processor pulses acknowledge twice. The first pulse leaves the bus undriven, and the second returns one byte: the five upper bits of a programmed base joined to the three-bit level. When automatic end-of-interrupt is enabled, a strobe follows the trailing edge of the last pulse. A separate enable steers external bus transceivers in buffered systems.

The acknowledge strobe is timed by the processor, so it cannot be held off. For this reason the data path has no valid/ready handshake. The bus value is qualified only by the drive output, and every other pin is plain control.

Top module: `intack_vector_seq`

## Requirements
- R1: After reset, bus_drive, bus_data, buf_en, isr_set, irr_clr and aeoi_stb are all 0 and act_level is 0.
- R2: With call_mode=1, a sequence is three acknowledge pulses returning 0xCD, then the low vector byte, then vec_hi unchanged.
- R3: With call_mode=1 and spacing4=1, the low vector byte is {vec_lo_top[2:0], level[2:0], 2'b00}.
- R4: With call_mode=1 and spacing4=0, the low vector byte is {vec_lo_top[2:1], level[2:0], 3'b000}; vec_lo_top[0] has no effect.
- R5: With call_mode=0, a sequence is two pulses. The first leaves bus_drive at 0, and the second returns {vec_hi[7:3], level[2:0]}.
- R6: On the first pulse of a sequence, isr_set and irr_clr are each high for exactly one cycle, the cycle after ack_n falls. act_level then shows the latched level, which is held until the next sequence regardless of req_level and req_valid.
- R7: aeoi_stb is high for one cycle, the cycle after ack_n rises at the end of the final pulse, if auto_eoi was 1 at the first pulse. Otherwise it stays 0.
- R8: If req_valid is 0 at the first pulse, the level used is 7 and isr_set, irr_clr and aeoi_stb all stay 0 for that sequence.
- R9: buf_en equals bus_drive while buffered=1 (sampled at each pulse's leading edge) and stays 0 while buffered=0.
- R10: bus_drive rises the cycle after ack_n falls on a driving pulse and falls the cycle after ack_n rises. bus_data is 0 whenever bus_drive is 0.
- R11: call_mode and auto_eoi are sampled at the first pulse. Changes to them during the sequence have no effect on its length or bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_n | input | 1 | Interrupt acknowledge strobe, active low, synchronous to clk |
| req_valid | input | 1 | Resolver has a pending unmasked request |
| req_level | input | 3 | Winning level from the resolver |
| vec_hi | input | 8 | High vector byte / type-number base (bits 7:3 used in type mode) |
| vec_lo_top | input | 3 | Top three bits of the low vector byte |
| call_mode | input | 1 | 1 = three-byte call response, 0 = type-number response |
| spacing4 | input | 1 | 1 = 4-byte vector spacing, 0 = 8-byte |
| auto_eoi | input | 1 | 1 = emit automatic end-of-interrupt strobe |
| buffered | input | 1 | 1 = drive buf_en alongside the bus |
| bus_data | output | 8 | Byte placed on the data bus |
| bus_drive | output | 1 | Data bus drive enable |
| buf_en | output | 1 | External transceiver enable |
| isr_set | output | 1 | Strobe: mark act_level in service |
| irr_clr | output | 1 | Strobe: clear request for act_level |
| aeoi_stb | output | 1 | Strobe: automatic end-of-interrupt for act_level |
| act_level | output | 3 | Level latched for the current sequence |

## Verification
The assertions watch the timing relations on every cycle. Drive only follows a sampled-low strobe, buf_en never appears without drive, the in-service strobe needs a pending request at the leading edge, end-of-interrupt follows a trailing edge, and the leading-edge and trailing-edge strobes never coincide. The byte contents depend on mode, spacing, base fields and the latched level, and only the bench scenarios can show them. The same holds for the spurious level 7, the holding of the level and mode against mid-sequence changes, and the silent first pulse in type-number mode.

// File: rtl/iav_pkg.sv
package iav_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LEVEL_W = 3;
  localparam int unsigned IDX_W   = 2;
  localparam logic [LEVEL_W-1:0] SPURIOUS_LEVEL = '1;

  typedef struct packed {
    logic               call_mode;
    logic               auto_eoi;
    logic               spurious;
    logic [LEVEL_W-1:0] level;
  } seq_ctx_t;
endpackage

// File: rtl/iav_strobe_edge.sv
module iav_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic lead,
  output logic trail
);
  logic strobe_d;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_d <= 1'b1;
    else        strobe_d <= strobe_n;
  end

  assign lead  = strobe_d & ~strobe_n;
  assign trail = ~strobe_d & strobe_n;
endmodule

// File: rtl/iav_phase_ctl.sv
module iav_phase_ctl
  import iav_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lead,
  input  logic               trail,
  input  logic               call_mode,
  input  logic               auto_eoi,
  input  logic               req_valid,
  input  logic [LEVEL_W-1:0] req_level,
  output logic [IDX_W-1:0]   idx,
  output logic               eff_mode,
  output seq_ctx_t           ctx,
  output logic               isr_set,
  output logic               irr_clr,
  output logic               aeoi_stb
);
  logic [IDX_W-1:0] last_idx;
  logic             first;

  assign first    = (idx == '0);
  assign eff_mode = first ? call_mode : ctx.call_mode;
  assign last_idx = ctx.call_mode ? IDX_W'(2) : IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      ctx      <= '0;
      isr_set  <= 1'b0;
      irr_clr  <= 1'b0;
      aeoi_stb <= 1'b0;
    end else begin
      isr_set  <= 1'b0;
      irr_clr  <= 1'b0;
      aeoi_stb <= 1'b0;
      if (lead && first) begin
        ctx.call_mode <= call_mode;
        ctx.auto_eoi  <= auto_eoi;
        ctx.spurious  <= ~req_valid;
        ctx.level     <= req_valid ? req_level : SPURIOUS_LEVEL;
        isr_set       <= req_valid;
        irr_clr       <= req_valid;
      end
      if (trail) begin
        if (idx == last_idx) begin
          idx      <= '0;
          aeoi_stb <= ctx.auto_eoi & ~ctx.spurious;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/iav_byte_gen.sv
module iav_byte_gen
  import iav_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CALL_OPCODE = 8'hCD
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic               mode_call,
  input  logic               spacing4,
  input  logic [2:0]         vec_lo_top,
  input  logic [BYTE_W-1:0]  vec_hi,
  input  logic [LEVEL_W-1:0] level,
  output logic [BYTE_W-1:0]  byte_out,
  output logic               want_drive
);
  localparam int unsigned TYPE_BASE_W = BYTE_W - LEVEL_W;

  logic [BYTE_W-1:0] lo_byte;
  logic [BYTE_W-1:0] type_byte;

  assign lo_byte   = spacing4 ? {vec_lo_top, level, 2'b00}
                              : {vec_lo_top[2:1], level, 3'b000};
  assign type_byte = {vec_hi[BYTE_W-1 -: TYPE_BASE_W], level};

  always_comb begin
    byte_out   = '0;
    want_drive = 1'b0;
    if (mode_call) begin
      want_drive = 1'b1;
      case (idx)
        2'd0:    byte_out = CALL_OPCODE;
        2'd1:    byte_out = lo_byte;
        default: byte_out = vec_hi;
      endcase
    end else if (idx == 2'd1) begin
      want_drive = 1'b1;
      byte_out   = type_byte;
    end
  end
endmodule

// File: rtl/intack_vector_seq.sv
module intack_vector_seq
  import iav_pkg::*;
#(
  parameter logic [7:0] CALL_OPCODE = 8'hCD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_n,
  input  logic       req_valid,
  input  logic [2:0] req_level,
  input  logic [7:0] vec_hi,
  input  logic [2:0] vec_lo_top,
  input  logic       call_mode,
  input  logic       spacing4,
  input  logic       auto_eoi,
  input  logic       buffered,
  output logic [7:0] bus_data,
  output logic       bus_drive,
  output logic       buf_en,
  output logic       isr_set,
  output logic       irr_clr,
  output logic       aeoi_stb,
  output logic [2:0] act_level
);
  logic             lead, trail;
  logic [IDX_W-1:0] idx;
  logic             eff_mode;
  seq_ctx_t         ctx;
  logic [7:0]       next_byte;
  logic             want_drive;

  iav_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .strobe_n(ack_n), .lead(lead), .trail(trail)
  );

  iav_phase_ctl u_phase (
    .clk(clk), .rst_n(rst_n), .lead(lead), .trail(trail),
    .call_mode(call_mode), .auto_eoi(auto_eoi),
    .req_valid(req_valid), .req_level(req_level),
    .idx(idx), .eff_mode(eff_mode), .ctx(ctx),
    .isr_set(isr_set), .irr_clr(irr_clr), .aeoi_stb(aeoi_stb)
  );

  iav_byte_gen #(.CALL_OPCODE(CALL_OPCODE)) u_byte (
    .idx(idx), .mode_call(eff_mode), .spacing4(spacing4),
    .vec_lo_top(vec_lo_top), .vec_hi(vec_hi), .level(ctx.level),
    .byte_out(next_byte), .want_drive(want_drive)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_drive <= 1'b0;
      bus_data  <= '0;
      buf_en    <= 1'b0;
    end else if (lead) begin
      bus_drive <= want_drive;
      bus_data  <= want_drive ? next_byte : 8'h00;
      buf_en    <= want_drive & buffered;
    end else if (trail) begin
      bus_drive <= 1'b0;
      bus_data  <= '0;
      buf_en    <= 1'b0;
    end
  end

  assign act_level = ctx.level;
endmodule

// File: rtl/iav_chk.sv
module iav_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_n,
  input logic       req_valid,
  input logic [7:0] bus_data,
  input logic       bus_drive,
  input logic       buf_en,
  input logic       isr_set,
  input logic       irr_clr,
  input logic       aeoi_stb
);
  p_drive_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> !$past(ack_n));

  p_idle_bus_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> bus_data == 8'h00);

  p_bufen_needs_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |-> bus_drive);

  p_isr_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    isr_set |-> ($past(req_valid) && !$past(ack_n)));

  p_irr_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irr_clr |-> $past(req_valid));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    isr_set |=> !isr_set);

  p_eoi_after_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    aeoi_stb |-> $past(ack_n));

  p_strobes_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({isr_set, aeoi_stb}));
endmodule

bind intack_vector_seq iav_chk u_iav_chk (
  .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .req_valid(req_valid),
  .bus_data(bus_data), .bus_drive(bus_drive), .buf_en(buf_en),
  .isr_set(isr_set), .irr_clr(irr_clr), .aeoi_stb(aeoi_stb)
);

// File: tb/tb_intack_vector_seq.sv
module tb_intack_vector_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack_n = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_level = '0;
  logic [7:0] vec_hi = '0;
  logic [2:0] vec_lo_top = '0;
  logic       call_mode = 1'b0;
  logic       spacing4 = 1'b0;
  logic       auto_eoi = 1'b0;
  logic       buffered = 1'b0;
  logic [7:0] bus_data;
  logic       bus_drive, buf_en, isr_set, irr_clr, aeoi_stb;
  logic [2:0] act_level;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  intack_vector_seq dut (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .req_valid(req_valid),
    .req_level(req_level), .vec_hi(vec_hi), .vec_lo_top(vec_lo_top),
    .call_mode(call_mode), .spacing4(spacing4), .auto_eoi(auto_eoi),
    .buffered(buffered), .bus_data(bus_data), .bus_drive(bus_drive),
    .buf_en(buf_en), .isr_set(isr_set), .irr_clr(irr_clr),
    .aeoi_stb(aeoi_stb), .act_level(act_level)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input bit cm, input bit s4, input logic [2:0] lt,
                                          input logic [7:0] hi, input logic [2:0] lv, input int p);
    if (!cm) return {hi[7:3], lv};
    if (p == 0) return 8'hCD;
    if (p == 2) return hi;
    return s4 ? {lt, lv, 2'b00} : {lt[2:1], lv, 3'b000};
  endfunction

  // One full acknowledge sequence; starts and ends at a negedge.
  task automatic run_seq(input bit cm, input bit s4, input bit ae, input bit bf,
                         input bit rv, input logic [2:0] lv, input logic [2:0] lt,
                         input logic [7:0] hi, input bit disturb);
    logic [2:0] lx;
    int np;
    lx = rv ? lv : 3'd7;
    np = cm ? 3 : 2;
    call_mode = cm; spacing4 = s4; auto_eoi = ae; buffered = bf;
    req_valid = rv; req_level = lv; vec_lo_top = lt; vec_hi = hi;
    @(negedge clk);
    for (int p = 0; p < np; p++) begin
      bit drv;
      drv = cm || (p == 1);
      ack_n = 1'b0;
      @(negedge clk);
      chk(cm ? "R2 drive" : "R5 drive", {31'd0, bus_drive}, {31'd0, drv});
      chk(cm ? (p == 1 ? (s4 ? "R3 byte" : "R4 byte") : "R2 byte") : "R5 byte",
          {24'd0, bus_data}, {24'd0, drv ? exp_byte(cm, s4, lt, hi, lx, p) : 8'h00});
      chk("R9 buf_en", {31'd0, buf_en}, {31'd0, drv & bf});
      chk("R6 isr_set", {31'd0, isr_set}, {31'd0, (p == 0) && rv});
      chk("R8 irr_clr", {31'd0, irr_clr}, {31'd0, (p == 0) && rv});
      chk("R6 act_level", {29'd0, act_level}, {29'd0, lx});
      if (p == 0 && disturb) begin
        req_level = ~lv; req_valid = ~rv; call_mode = ~cm; auto_eoi = ~ae;
      end
      @(negedge clk);
      chk("R6 isr_set one cycle", {31'd0, isr_set}, 32'd0);
      chk("R11 drive held", {31'd0, bus_drive}, {31'd0, drv});
      ack_n = 1'b1;
      @(negedge clk);
      chk("R10 drive release", {31'd0, bus_drive}, 32'd0);
      chk("R10 idle data", {24'd0, bus_data}, 32'd0);
      chk("R7 aeoi_stb", {31'd0, aeoi_stb}, {31'd0, (p == np - 1) && ae && rv});
      @(negedge clk);
      chk("R7 aeoi one cycle", {31'd0, aeoi_stb}, 32'd0);
    end
    chk("R11 level held", {29'd0, act_level}, {29'd0, lx});
  endtask

  initial begin
    void'($urandom(32'd7019));
    repeat (3) @(negedge clk);
    chk("R1 bus_drive", {31'd0, bus_drive}, 32'd0);
    chk("R1 bus_data", {24'd0, bus_data}, 32'd0);
    chk("R1 strobes", {29'd0, isr_set, irr_clr, aeoi_stb}, 32'd0);
    chk("R1 buf_en", {31'd0, buf_en}, 32'd0);
    chk("R1 act_level", {29'd0, act_level}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_seq(0, 0, 1, 1, 1, 3'd0, 3'b000, 8'hA8, 0);   // R5 base A8 level0 -> A8
    run_seq(0, 0, 1, 1, 1, 3'd7, 3'b000, 8'hA8, 0);   // R5 level7 -> AF
    run_seq(1, 1, 0, 0, 1, 3'd1, 3'b100, 8'h24, 0);   // R3 -> 0x84
    run_seq(1, 0, 0, 0, 1, 3'd1, 3'b100, 8'h24, 0);   // R4 -> 0x88
    run_seq(1, 0, 0, 0, 1, 3'd1, 3'b101, 8'h24, 0);   // R4 A5 ignored -> 0x88
    run_seq(1, 1, 1, 1, 0, 3'd2, 3'b011, 8'h55, 0);   // R8 spurious call
    run_seq(0, 0, 1, 0, 0, 3'd4, 3'b000, 8'h40, 1);   // R8 spurious type, disturbed
    run_seq(1, 1, 1, 1, 1, 3'd5, 3'b010, 8'h9C, 1);   // R11 mode change ignored
    run_seq(0, 1, 1, 1, 1, 3'd3, 3'b111, 8'hF0, 1);   // R11 type then disturbed

    // Random mix
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      r = $urandom();
      run_seq(r[0], r[1], r[2], r[3], (r[6:4] != 3'd0), r[9:7], r[12:10],
              r[20:13], r[21]);
    end

    summary();
    $finish;
  end
endmodule